// File: doc/BRIEF.md
# Byte-serial accumulator processor core

This block is a compact multi-cycle processor with 8-bit data, two accumulators (A and B) and a 16-bit index register Y. It moves every byte over a single 8-bit memory port, one byte per clock. Opcode bytes, address bytes and operand bytes come in strictly one after another. After the last read it performs the operation and then writes the result back, either to a register or to memory through a single write cycle.

The memory port is synchronous and the core expects a combinational read: in a cycle with `bus_rd` high, the memory drives the byte at `bus_addr` onto `bus_rdata`, and the core captures it at the next rising edge. In a cycle with `bus_wr` high, the memory stores `bus_wdata` at `bus_addr` at that edge. The `bus_sync` output marks each cycle that fetches the first byte of an instruction. The core supports immediate, zero-page and full 16-bit absolute addressing, a handful of single-byte register operations, and one two-byte opcode that starts with a prefix byte. Any other opcode stops the core for good and raises an error flag.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, the core holds A, B and Y at zero, keeps `illegal` low and `bus_wr` low, and presents `START_PC` (default 16'hC000) on `bus_addr` with `bus_rd` and `bus_sync` high.
- R2: Each instruction byte is read from the address one above the byte before it. The next opcode is fetched at the start address plus the length of the instruction just completed.
- R3: Loads: 86 loads A from the next byte, 96 loads A from zero-page address {8'h00, next byte}, B6 loads A from a 16-bit address whose high byte comes first, C6 loads B from the next byte, and D6 loads B from zero-page.
- R4: Add to A, modulo 256: 8B takes the next byte, 9B takes a zero-page byte, and BB takes a byte at a 16-bit address.
- R5: Stores: 5A (zero-page) and 7A (16-bit address) write A with exactly one write cycle, and `bus_wr` is high for one clock only.
- R6: Single-byte register operations: 42 adds 1 to A modulo 256; 48 shifts A left with 0 entering bit 0; 54 shifts B right with 0 entering bit 7; 02 adds 1 to Y modulo 2^16.
- R7: The two-byte opcode 18 06 adds B to A modulo 256.
- R8: Cycle counts: 2 for the immediate forms and the one-byte register operations; 3 for the zero-page forms and for 18 06; 4 for the 16-bit-address forms.
- R9: Any opcode not listed, or a byte other than 06 after 18, stops the core after that byte. `illegal` then stays high, the bus stays idle and the registers stay unchanged until reset.
- R10: `bus_rd` and `bus_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | output | ADDR_W | Memory address for the current cycle |
| bus_rd | output | 1 | Read strobe; memory drives `bus_rdata` |
| bus_wr | output | 1 | Write strobe; memory stores `bus_wdata` at the edge |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in a cycle with `bus_rd` high |
| bus_sync | output | 1 | High in each first-opcode-byte fetch cycle |
| reg_a | output | DATA_W | Accumulator A |
| reg_b | output | DATA_W | Accumulator B |
| reg_y | output | ADDR_W | Index register Y |
| illegal | output | 1 | Sticky undecodable-opcode flag |

## Verification
The bench sets up data where the arithmetic wraps: INCA on FF, ADDA and ABA sums that cross 256, and shift patterns with both end bits set. A core that carried the wrong bit in, or that failed to wrap, would leave a wrong accumulator value. Random programs mix all three address modes and compare the address of every opcode fetch and the total cycle count against a model. An operand fetched from the wrong place, or a mishandled high/low address order, shows up as a wrong load result or as a store at the wrong location. The illegal cases are an unknown opcode and a prefix byte followed by a wrong second byte. For these the bench checks that the core stops after the right number of cycles and then stays off the bus, which a core that kept fetching would break.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam logic [7:0] OPC_LDA_IMM = 8'h86;
   localparam logic [7:0] OPC_LDA_DIR = 8'h96;
   localparam logic [7:0] OPC_LDA_EXT = 8'hB6;
   localparam logic [7:0] OPC_LDB_IMM = 8'hC6;
   localparam logic [7:0] OPC_LDB_DIR = 8'hD6;
   localparam logic [7:0] OPC_ADA_IMM = 8'h8B;
   localparam logic [7:0] OPC_ADA_DIR = 8'h9B;
   localparam logic [7:0] OPC_ADA_EXT = 8'hBB;
   localparam logic [7:0] OPC_STA_DIR = 8'h5A;
   localparam logic [7:0] OPC_STA_EXT = 8'h7A;
   localparam logic [7:0] OPC_INC_A   = 8'h42;
   localparam logic [7:0] OPC_SHL_A   = 8'h48;
   localparam logic [7:0] OPC_SHR_B   = 8'h54;
   localparam logic [7:0] OPC_INC_Y   = 8'h02;
   localparam logic [7:0] OPC_PREFIX  = 8'h18;
   localparam logic [7:0] OPC_P_ADDAB = 8'h06;

   typedef enum logic [2:0] {
      K_LD, K_ADD, K_ST, K_INCA, K_SHLA, K_SHRB, K_INCY, K_ADDAB
   } op_kind_t;

   typedef enum logic [2:0] {
      M_INH, M_IMM, M_DIR, M_EXT, M_PRE
   } op_mode_t;

   typedef struct packed {
      logic     legal;
      op_kind_t kind;
      op_mode_t mode;
      logic     to_b;
   } op_info_t;

   typedef enum logic [2:0] {
      S_FETCH, S_PRE, S_ADH, S_ADL, S_OPND, S_EXEC, S_WRITE, S_HALT
   } cpu_state_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
(
   input  logic [7:0] opc,
   output op_info_t   info
);
   always_comb begin
      info       = '0;
      info.legal = 1'b1;
      case (opc)
         OPC_LDA_IMM: begin info.kind = K_LD;    info.mode = M_IMM; end
         OPC_LDA_DIR: begin info.kind = K_LD;    info.mode = M_DIR; end
         OPC_LDA_EXT: begin info.kind = K_LD;    info.mode = M_EXT; end
         OPC_LDB_IMM: begin info.kind = K_LD;    info.mode = M_IMM; info.to_b = 1'b1; end
         OPC_LDB_DIR: begin info.kind = K_LD;    info.mode = M_DIR; info.to_b = 1'b1; end
         OPC_ADA_IMM: begin info.kind = K_ADD;   info.mode = M_IMM; end
         OPC_ADA_DIR: begin info.kind = K_ADD;   info.mode = M_DIR; end
         OPC_ADA_EXT: begin info.kind = K_ADD;   info.mode = M_EXT; end
         OPC_STA_DIR: begin info.kind = K_ST;    info.mode = M_DIR; end
         OPC_STA_EXT: begin info.kind = K_ST;    info.mode = M_EXT; end
         OPC_INC_A:   begin info.kind = K_INCA;  info.mode = M_INH; end
         OPC_SHL_A:   begin info.kind = K_SHLA;  info.mode = M_INH; end
         OPC_SHR_B:   begin info.kind = K_SHRB;  info.mode = M_INH; end
         OPC_INC_Y:   begin info.kind = K_INCY;  info.mode = M_INH; end
         OPC_PREFIX:  begin info.kind = K_ADDAB; info.mode = M_PRE; end
         default:     info.legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DW = 8,
   parameter int YW = 16
)(
   input  op_kind_t        kind,
   input  logic            to_b,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic [YW-1:0]   y,
   input  logic [DW-1:0]   opnd,
   output logic [DW-1:0]   a_n,
   output logic [DW-1:0]   b_n,
   output logic [YW-1:0]   y_n
);
   localparam logic [DW-1:0] ONE_D = DW'(1);
   localparam logic [YW-1:0] ONE_Y = YW'(1);

   always_comb begin
      a_n = a;
      b_n = b;
      y_n = y;
      case (kind)
         K_LD:    if (to_b) b_n = opnd; else a_n = opnd;
         K_ADD:   a_n = a + opnd;
         K_INCA:  a_n = a + ONE_D;
         K_SHLA:  a_n = {a[DW-2:0], 1'b0};
         K_SHRB:  b_n = {1'b0, b[DW-1:1]};
         K_INCY:  y_n = y + ONE_Y;
         K_ADDAB: a_n = a + b;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int              DATA_W   = 8,
   parameter int              ADDR_W   = 16,
   parameter logic [15:0]     START_PC = 16'hC000
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              bus_sync,
   output logic [DATA_W-1:0] reg_a,
   output logic [DATA_W-1:0] reg_b,
   output logic [ADDR_W-1:0] reg_y,
   output logic              illegal
);
   localparam int              HALF_W  = ADDR_W / 2;
   localparam logic [HALF_W-1:0] ZP_PAGE = '0;
   localparam logic [ADDR_W-1:0] PC_RST  = ADDR_W'(START_PC);
   localparam logic [ADDR_W-1:0] PC_ONE  = ADDR_W'(1);

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("acc_cpu: opcodes are bytes, DATA_W must be 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_aw
         $error("acc_cpu: ADDR_W must hold exactly two data bytes");
      end
   endgenerate

   cpu_state_t        st;
   op_info_t          cur;
   op_info_t          dec;
   logic [ADDR_W-1:0] pc;
   logic [HALF_W-1:0] ea_hi, ea_lo;
   logic [DATA_W-1:0] a_q, b_q, a_n, b_n;
   logic [ADDR_W-1:0] y_q, y_n;
   logic              ill_q;
   logic              do_exec;

   acc_cpu_decode u_dec (
      .opc  (bus_rdata),
      .info (dec)
   );

   acc_cpu_alu #(.DW(DATA_W), .YW(ADDR_W)) u_alu (
      .kind (cur.kind),
      .to_b (cur.to_b),
      .a    (a_q),
      .b    (b_q),
      .y    (y_q),
      .opnd (bus_rdata),
      .a_n  (a_n),
      .b_n  (b_n),
      .y_n  (y_n)
   );

   // bus drive per state
   always_comb begin
      bus_addr = pc;
      bus_rd   = 1'b0;
      bus_wr   = 1'b0;
      case (st)
         S_FETCH, S_PRE, S_ADH, S_ADL: bus_rd = 1'b1;
         S_OPND: begin
            bus_rd   = 1'b1;
            bus_addr = (cur.mode == M_IMM) ? pc : {ea_hi, ea_lo};
         end
         S_WRITE: begin
            bus_wr   = 1'b1;
            bus_addr = {ea_hi, ea_lo};
         end
         default: ;
      endcase
   end

   assign bus_wdata = a_q;
   assign bus_sync  = (st == S_FETCH);
   assign do_exec   = (st == S_OPND) || (st == S_EXEC);

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_FETCH;
         pc    <= PC_RST;
         cur   <= '0;
         ea_hi <= '0;
         ea_lo <= '0;
         ill_q <= 1'b0;
      end else begin
         case (st)
            S_FETCH: begin
               pc    <= pc + PC_ONE;
               ea_hi <= ZP_PAGE;
               cur   <= dec;
               if (!dec.legal) begin
                  st    <= S_HALT;
                  ill_q <= 1'b1;
               end else begin
                  case (dec.mode)
                     M_INH:   st <= S_EXEC;
                     M_PRE:   st <= S_PRE;
                     M_IMM:   st <= S_OPND;
                     M_DIR:   st <= S_ADL;
                     default: st <= S_ADH;
                  endcase
               end
            end
            S_PRE: begin
               pc <= pc + PC_ONE;
               if (bus_rdata == OPC_P_ADDAB) begin
                  cur.kind <= K_ADDAB;
                  cur.mode <= M_INH;
                  st       <= S_EXEC;
               end else begin
                  st    <= S_HALT;
                  ill_q <= 1'b1;
               end
            end
            S_ADH: begin
               pc    <= pc + PC_ONE;
               ea_hi <= bus_rdata;
               st    <= S_ADL;
            end
            S_ADL: begin
               pc    <= pc + PC_ONE;
               ea_lo <= bus_rdata;
               st    <= (cur.kind == K_ST) ? S_WRITE : S_OPND;
            end
            S_OPND: begin
               if (cur.mode == M_IMM) pc <= pc + PC_ONE;
               st <= S_FETCH;
            end
            S_EXEC:  st <= S_FETCH;
            S_WRITE: st <= S_FETCH;
            default: st <= S_HALT;
         endcase
      end
   end

   // architectural registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         y_q <= '0;
      end else if (do_exec) begin
         a_q <= a_n;
         b_q <= b_n;
         y_q <= y_n;
      end
   end

   assign reg_a   = a_q;
   assign reg_b   = b_q;
   assign reg_y   = y_q;
   assign illegal = ill_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int DW = 8,
   parameter int AW = 16
)(
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_rd,
   input logic          bus_wr,
   input logic          bus_sync,
   input logic [DW-1:0] reg_a,
   input logic [AW-1:0] reg_y,
   input logic          illegal
);
   p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   p_wr_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_wr);

   p_ill_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> illegal);

   p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!bus_rd && !bus_wr && !bus_sync));

   p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && $past(illegal)) |-> $stable(reg_a));

   p_next_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sync && bus_rd) |=> (!bus_rd || bus_addr == $past(bus_addr) + 1'b1));

   p_y_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_y) |-> (reg_y == $past(reg_y) + 1'b1));
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_sync (bus_sync),
   .reg_a    (reg_a),
   .reg_y    (reg_y),
   .illegal  (illegal)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr;
   logic        bus_rd, bus_wr, bus_sync, illegal;
   logic [7:0]  bus_wdata, bus_rdata, reg_a, reg_b;
   logic [15:0] reg_y;

   logic [7:0]  mem   [0:511];
   logic [7:0]  mmod  [0:511];
   logic [15:0] starts[0:63];
   int          n_chk = 0, n_err = 0;
   int          pos, ninst, exp_cyc, exp_wr;
   logic [7:0]  ma, mb;
   logic [15:0] my;

   always #5 clk = ~clk;

   acc_cpu u_acc_cpu (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_sync(bus_sync), .reg_a(reg_a), .reg_b(reg_b), .reg_y(reg_y),
      .illegal(illegal)
   );

   assign bus_rdata = mem[bus_addr[8:0]];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] v);
      mem[pos[8:0]] = v;
      pos++;
   endtask

   task automatic begin_prog();
      pos = 0; ninst = 0; exp_cyc = 0; exp_wr = 0;
      ma = 8'h00; mb = 8'h00; my = 16'h0000;
      for (int i = 0; i < 128; i++) mem[i] = 8'h00;
      for (int i = 128; i < 512; i++) begin
         mem[i]  = 8'($urandom);
         mmod[i] = mem[i];
      end
   endtask

   // one instruction with the modelled effect; kind numbers are bench-local
   task automatic emit(input int k, input logic [7:0] v, input logic [15:0] ad);
      starts[ninst] = 16'hC000 + 16'(pos);
      ninst++;
      case (k)
         0:  begin put(8'h86); put(v);  ma = v; exp_cyc += 2; end
         1:  begin put(8'h96); put(ad[7:0]); ma = mmod[ad[8:0]]; exp_cyc += 3; end
         2:  begin put(8'hB6); put(ad[15:8]); put(ad[7:0]); ma = mmod[ad[8:0]]; exp_cyc += 4; end
         3:  begin put(8'hC6); put(v);  mb = v; exp_cyc += 2; end
         4:  begin put(8'hD6); put(ad[7:0]); mb = mmod[ad[8:0]]; exp_cyc += 3; end
         5:  begin put(8'h8B); put(v);  ma = ma + v; exp_cyc += 2; end
         6:  begin put(8'h9B); put(ad[7:0]); ma = ma + mmod[ad[8:0]]; exp_cyc += 3; end
         7:  begin put(8'hBB); put(ad[15:8]); put(ad[7:0]); ma = ma + mmod[ad[8:0]]; exp_cyc += 4; end
         8:  begin put(8'h5A); put(ad[7:0]); mmod[ad[8:0]] = ma; exp_wr++; exp_cyc += 3; end
         9:  begin put(8'h7A); put(ad[15:8]); put(ad[7:0]); mmod[ad[8:0]] = ma; exp_wr++; exp_cyc += 4; end
         10: begin put(8'h42); ma = ma + 8'd1; exp_cyc += 2; end
         11: begin put(8'h48); ma = {ma[6:0], 1'b0}; exp_cyc += 2; end
         12: begin put(8'h54); mb = {1'b0, mb[7:1]}; exp_cyc += 2; end
         13: begin put(8'h02); my = my + 16'd1; exp_cyc += 2; end
         default: begin put(8'h18); put(8'h06); ma = ma + mb; exp_cyc += 3; end
      endcase
   endtask

   function automatic logic [15:0] pick_addr(input int k);
      if (k == 1 || k == 4 || k == 6 || k == 8) return 16'h0080 + 16'($urandom_range(0, 127));
      return 16'h2100 + 16'($urandom_range(0, 255));
   endfunction

   // terminate, reset, run to halt and compare
   task automatic run_prog(input bit bad_pre, input string tag);
      int cyc, sync_i, wr_seen, overlap;
      logic [7:0] a_h;
      starts[ninst] = 16'hC000 + 16'(pos);
      ninst++;
      if (bad_pre) begin put(8'h18); put(8'h07); exp_cyc += 2; end
      else begin put(8'hFF); exp_cyc += 1; end
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0; sync_i = 0; wr_seen = 0; overlap = 0;
      forever begin
         if (illegal) break;
         if (bus_rd && bus_wr) overlap++;
         if (bus_sync) begin
            check(sync_i < ninst && bus_addr == starts[sync_i], "R2 fetch address",
                  int'(bus_addr), int'(starts[sync_i]));
            sync_i++;
         end
         if (bus_wr) begin
            wr_seen++;
            mem[bus_addr[8:0]] = bus_wdata;
         end
         @(negedge clk);
         cyc++;
         if (cyc > 1000) break;
      end
      check(cyc == exp_cyc, "R8 cycles to halt", cyc, exp_cyc);
      check(sync_i == ninst, "R2 opcode fetch count", sync_i, ninst);
      check(reg_a == ma, {tag, " reg A"}, int'(reg_a), int'(ma));
      check(reg_b == mb, {tag, " reg B"}, int'(reg_b), int'(mb));
      check(reg_y == my, {tag, " reg Y"}, int'(reg_y), int'(my));
      check(wr_seen == exp_wr, "R5 write cycles", wr_seen, exp_wr);
      begin
         int bad = 0;
         for (int i = 128; i < 512; i++) if (mem[i] != mmod[i]) bad++;
         check(bad == 0, "R5 data memory", bad, 0);
      end
      check(overlap == 0, "R10 rd/wr overlap", overlap, 0);
      a_h = reg_a;
      repeat (3) @(negedge clk);
      check(illegal && !bus_rd && !bus_wr && reg_a == a_h, "R9 halted and idle",
            {illegal, bus_rd, bus_wr}, 3'b100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      begin_prog();
      @(negedge clk);
      // R1 reset state
      check(bus_addr == 16'hC000 && bus_rd && bus_sync && !bus_wr, "R1 reset bus",
            int'(bus_addr), 16'hC000);
      check(reg_a == 0 && reg_b == 0 && reg_y == 0 && !illegal, "R1 reset regs",
            int'({reg_a, reg_b}), 0);

      // R6 wraps and shifts
      begin_prog();
      emit(0, 8'hFF, 0); emit(10, 0, 0);
      emit(3, 8'h81, 0); emit(12, 0, 0);
      emit(13, 0, 0); emit(13, 0, 0); emit(13, 0, 0);
      run_prog(1'b0, "R6 inca-wrap/lsrb/iny");
      begin_prog();
      emit(0, 8'h81, 0); emit(11, 0, 0);
      run_prog(1'b0, "R6 lsla");

      // R7 prefixed add, R4 add wrap
      begin_prog();
      emit(0, 8'hF0, 0); emit(3, 8'h20, 0); emit(14, 0, 0);
      run_prog(1'b0, "R7 aba wrap");
      begin_prog();
      emit(0, 8'hC8, 0); emit(5, 8'h64, 0); emit(6, 0, 16'h00A5); emit(7, 0, 16'h21C3);
      run_prog(1'b0, "R4 adda modes");

      // R3 store then reload through each address mode
      begin_prog();
      emit(0, 8'h5C, 0); emit(9, 0, 16'h2134); emit(8, 0, 16'h0090);
      emit(0, 8'h00, 0); emit(2, 0, 16'h2134); emit(4, 0, 16'h0090);
      emit(1, 0, 16'h00FF);
      run_prog(1'b0, "R3 load/store");

      // R9 wrong byte after prefix
      begin_prog();
      emit(0, 8'h33, 0);
      run_prog(1'b1, "R9 bad prefix");

      // random programs
      for (int p = 0; p < 40; p++) begin
         int n;
         begin_prog();
         n = $urandom_range(1, 14);
         for (int j = 0; j < n; j++) begin
            int k;
            k = $urandom_range(0, 14);
            emit(k, 8'($urandom), pick_addr(k));
         end
         run_prog(($urandom_range(0, 3) == 0), "R3 R4 R6 R7 random");
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule